// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

This block is a timer owned by a single processor core. Software writes a start value. The block counts it down at a rate taken from the input clock through a programmable prescaler. When the count expires, the block raises a one-cycle interrupt request that carries a programmed vector. There are three modes. Periodic mode reloads the count and repeats. One-shot mode fires once and then holds at zero. Deadline mode fires once when a free-running 64-bit timestamp input reaches a programmed 64-bit deadline.

Software reaches the timer through a word-wide register port with a single-cycle write strobe and a combinational read mux. The register offsets are:

| Offset | Register | Access |
|--------|----------|--------|
| 0x320 | Control (vector, mask, mode) | read/write |
| 0x380 | Start count | read/write |
| 0x390 | Live count | read-only |
| 0x3A0 | Deadline low half | write-only |
| 0x3B0 | Deadline high half | write-only |
| 0x3E0 | Prescale select | read/write |

Unmapped offsets read as zero. While deadline mode is selected, writes to the start count are ignored.

Top module: `cdt_timer`

## Requirements
- R1: After reset, the registers read as follows:
  - control reads 0x00010000 (masked, one-shot, vector 0);
  - start count reads 0;
  - live count reads 0;
  - prescale select reads 0.
  
  Control keeps only bits 7:0 (vector), bit 16 (mask) and bits 18:17 (mode: 00 one-shot, 01 periodic, 10 deadline). Prescale select keeps only bits 3, 1 and 0. All other bits read as zero.
- R2: The prescale code {bit3, bit1, bit0} selects the ratio between clock cycles and count decrements: 000=2, 001=4, 010=8, 011=16, 100=32, 101=64, 110=128, 111=1.
- R3: A write to the start count (offset 0x380) outside deadline mode loads the live count on the same edge and starts the countdown. The live count then falls by one every ratio cycles. 0xFFFFFFFF is a valid start value.
- R4: In one-shot mode, a start count N at ratio R gives exactly one interrupt, visible N*R cycles after the write edge. The live count then stays at zero.
- R5: In periodic mode, the live count reloads from the start count at each expiry, so interrupts repeat every N*R cycles.
- R6: While the mask bit is set, the countdown keeps running but no interrupt is issued. An expiry that occurs while masked is discarded and does not fire when the mask is later cleared.
- R7: Writing a start count of zero stops the countdown. The live count reads zero and no further interrupts occur.
- R8: Every write to the start count restarts the prescaler phase, so the first decrement follows a full ratio period.
- R9: When a start count write lands on the same edge as an expiry, the expiry interrupt is still issued, but the live count takes the written value rather than the periodic reload.
- R10: In deadline mode, one interrupt is issued one cycle after the first cycle in which the timestamp is at or above the armed deadline. The timer then disarms. Writing the low half (0x3A0) only stages it. Writing the high half (0x3B0) arms the timer with the combined 64-bit value.
- R11: Writing a combined deadline of zero leaves the timer disarmed, so no interrupt is issued.
- R12: Each interrupt is a single-cycle pulse of `irq_pulse`. During that cycle, `irq_vector` equals the control vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ts_in | input | 64 | Free-running timestamp |
| irq_pulse | output | 1 | Interrupt request pulse |
| irq_vector | output | 8 | Vector accompanying the pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit count, a 64-bit timestamp and an 8-bit prescaler. These defaults make the full 0xFFFFFFFF start value and the 128 ratio legal. The divide-by-1 code lets expiries be placed on exact edges, which is how the collision between a start-count write and an expiry is reached. Divide-by-4 and divide-by-16 show that the prescaler phase is restarted. The timestamp runs above 2^32, so the deadline compare depends on its upper half.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int VEC_W = 8;

    localparam int OFF_CTRL  = 'h320;
    localparam int OFF_START = 'h380;
    localparam int OFF_LIVE  = 'h390;
    localparam int OFF_DL_LO = 'h3A0;
    localparam int OFF_DL_HI = 'h3B0;
    localparam int OFF_PSC   = 'h3E0;

    localparam int CTRL_MASK_BIT = 16;
    localparam int CTRL_MODE_LSB = 17;

    typedef enum logic [1:0] {
        MODE_ONESHOT  = 2'b00,
        MODE_PERIODIC = 2'b01,
        MODE_DEADLINE = 2'b10,
        MODE_RSVD     = 2'b11
    } mode_e;

    typedef struct packed {
        mode_e              mode;
        logic               mask;
        logic [VEC_W-1:0]   vector;
    } ctrl_t;

    // Prescale code -> clock cycles per decrement (1..128)
    function automatic logic [7:0] psc_ratio(input logic [2:0] code);
        if (code == 3'b111) return 8'd1;
        return 8'd2 << code;
    endfunction

endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic [2:0] code,
    output logic       tick
);
    import cdt_pkg::*;

    logic [PSC_W-1:0] phase_q;
    logic [PSC_W-1:0] limit;

    assign limit = PSC_W'(psc_ratio(code) - 8'd1);
    // >= keeps the phase bounded when the ratio is lowered mid-period
    assign tick  = (phase_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || restart) phase_q <= '0;
        else if (tick)      phase_q <= '0;
        else                phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/cdt_downcounter.sv
module cdt_downcounter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             enable,
    input  logic             periodic,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign expire = enable && tick && (count == ONE);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (enable && tick && (count != '0)) begin
            if (count == ONE) count <= periodic ? reload_val : '0;
            else              count <= count - ONE;
        end
    end
endmodule

// File: rtl/cdt_deadline.sv
module cdt_deadline #(
    parameter int TS_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [TS_W/2-1:0] wdata,
    input  logic              enable,
    input  logic [TS_W-1:0]   ts,
    output logic              fire,
    output logic              armed
);
    localparam int HALF_W = TS_W / 2;

    logic [HALF_W-1:0] lo_stage_q;
    logic [TS_W-1:0]   target_q;
    logic [TS_W-1:0]   target_nx;

    assign target_nx = {wdata, lo_stage_q};
    assign fire      = armed && enable && (ts >= target_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_stage_q <= '0;
            target_q   <= '0;
            armed      <= 1'b0;
        end else begin
            if (wr_lo) lo_stage_q <= wdata;
            if (wr_hi) begin
                target_q <= target_nx;
                armed    <= (target_nx != '0);
            end else if (fire) begin
                armed    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int TS_W   = 64,
    parameter int ADDR_W = 12,
    parameter int PSC_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic [TS_W-1:0]   ts_in,
    output logic              irq_pulse,
    output logic [VEC_W-1:0]  irq_vector
);
    localparam ctrl_t CTRL_RST = '{mode: MODE_ONESHOT, mask: 1'b1, vector: '0};

    ctrl_t            ctrl_q;
    logic [2:0]       psc_code_q;
    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] cur_cnt;

    logic wr_ctrl, wr_start, wr_dl_lo, wr_dl_hi, wr_psc;
    logic dl_mode, periodic, cnt_load, tick, cnt_expire, dl_fire, dl_armed;

    assign wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(OFF_CTRL));
    assign wr_start = reg_wr && (reg_addr == ADDR_W'(OFF_START));
    assign wr_dl_lo = reg_wr && (reg_addr == ADDR_W'(OFF_DL_LO));
    assign wr_dl_hi = reg_wr && (reg_addr == ADDR_W'(OFF_DL_HI));
    assign wr_psc   = reg_wr && (reg_addr == ADDR_W'(OFF_PSC));

    assign dl_mode  = (ctrl_q.mode == MODE_DEADLINE);
    assign periodic = (ctrl_q.mode == MODE_PERIODIC);
    assign cnt_load = wr_start && !dl_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= CTRL_RST;
            psc_code_q <= '0;
            start_q    <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.mode   <= mode_e'(reg_wdata[CTRL_MODE_LSB +: 2]);
                ctrl_q.mask   <= reg_wdata[CTRL_MASK_BIT];
                ctrl_q.vector <= reg_wdata[VEC_W-1:0];
            end
            if (wr_psc)   psc_code_q <= {reg_wdata[3], reg_wdata[1:0]};
            if (cnt_load) start_q    <= reg_wdata;
        end
    end

    cdt_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .restart (cnt_load),
        .code    (psc_code_q),
        .tick    (tick)
    );

    cdt_downcounter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load       (cnt_load),
        .load_val   (reg_wdata),
        .tick       (tick),
        .enable     (!dl_mode),
        .periodic   (periodic),
        .reload_val (start_q),
        .count      (cur_cnt),
        .expire     (cnt_expire)
    );

    cdt_deadline #(.TS_W(TS_W)) u_dl (
        .clk    (clk),
        .rst    (rst),
        .wr_lo  (wr_dl_lo),
        .wr_hi  (wr_dl_hi),
        .wdata  (reg_wdata[TS_W/2-1:0]),
        .enable (dl_mode),
        .ts     (ts_in),
        .fire   (dl_fire),
        .armed  (dl_armed)
    );

    // Mask is sampled at expiry: a masked expiry is discarded, never held
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pulse  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_pulse  <= (cnt_expire || dl_fire) && !ctrl_q.mask;
            irq_vector <= ctrl_q.vector;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFF_CTRL): begin
                reg_rdata[CTRL_MODE_LSB +: 2] = ctrl_q.mode;
                reg_rdata[CTRL_MASK_BIT]      = ctrl_q.mask;
                reg_rdata[VEC_W-1:0]          = ctrl_q.vector;
            end
            ADDR_W'(OFF_START): reg_rdata = start_q;
            ADDR_W'(OFF_LIVE):  reg_rdata = cur_cnt;
            ADDR_W'(OFF_PSC):   reg_rdata[3:0] = {psc_code_q[2], 1'b0, psc_code_q[1:0]};
            default:            reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             irq_pulse,
    input logic             mask,
    input logic [1:0]       mode,
    input logic             load,
    input logic [CNT_W-1:0] wdata,
    input logic [CNT_W-1:0] cur,
    input logic             expire,
    input logic             dl_fire,
    input logic             dl_armed
);
    a_r3_load_takes_value: assert property (@(posedge clk) disable iff (rst)
        load |=> (cur == $past(wdata)));

    a_r4_oneshot_rests: assert property (@(posedge clk) disable iff (rst)
        (expire && (mode == 2'b00) && !load) |=> (cur == '0));

    a_r6_masked_silent: assert property (@(posedge clk) disable iff (rst)
        $past(mask) |-> !irq_pulse);

    a_r7_stopped_stays: assert property (@(posedge clk) disable iff (rst)
        ((cur == '0) && !load) |=> (cur == '0));

    a_r10_disarm_after_fire: assert property (@(posedge clk) disable iff (rst)
        dl_fire |=> !dl_armed);
endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_pulse (irq_pulse),
    .mask      (ctrl_q.mask),
    .mode      (ctrl_q.mode),
    .load      (cnt_load),
    .wdata     (reg_wdata),
    .cur       (cur_cnt),
    .expire    (cnt_expire),
    .dl_fire   (dl_fire),
    .dl_armed  (dl_armed)
);

// File: tb/cdt_timer_bench.sv
module cdt_timer_bench;
    localparam logic [11:0] A_CTRL  = 12'h320;
    localparam logic [11:0] A_START = 12'h380;
    localparam logic [11:0] A_LIVE  = 12'h390;
    localparam logic [11:0] A_DL_LO = 12'h3A0;
    localparam logic [11:0] A_DL_HI = 12'h3B0;
    localparam logic [11:0] A_PSC   = 12'h3E0;
    localparam logic [63:0] TS_BASE = 64'h0000_0001_0000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] ts_in;
    logic        irq_pulse;
    logic [7:0]  irq_vector;
    logic [31:0] cyc = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int n_unexp = 0;
    logic [39:0] exp_q[$];
    string       tag_q[$];
    logic [39:0] ent;
    string       etag;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign ts_in = TS_BASE + 64'(cyc);

    cdt_timer u_cdt_timer (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ts_in(ts_in),
        .irq_pulse(irq_pulse), .irq_vector(irq_vector)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_irq(input logic [31:0] c, input logic [7:0] v, input string tag);
        exp_q.push_back({c, v});
        tag_q.push_back(tag);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (irq_pulse) begin
                n_cmp++;
                if (exp_q.size() == 0) begin
                    n_unexp++;
                    n_bad++;
                    $display("FAIL R12 unexpected irq actual=cycle %0d vec %0h expected=none",
                             cyc, irq_vector);
                end else begin
                    ent  = exp_q.pop_front();
                    etag = tag_q.pop_front();
                    if (ent !== {cyc, irq_vector}) begin
                        n_bad++;
                        $display("FAIL %s irq actual=cycle %0d vec %0h expected=cycle %0d vec %0h",
                                 etag, cyc, irq_vector, ent[39:8], ent[7:0]);
                    end
                end
            end else if (exp_q.size() > 0 && exp_q[0][39:8] < cyc) begin
                ent  = exp_q.pop_front();
                etag = tag_q.pop_front();
                n_cmp++;
                n_bad++;
                $display("FAIL %s irq missing actual=none expected=cycle %0d vec %0h",
                         etag, ent[39:8], ent[7:0]);
            end
        end
    end

    task automatic wait_cyc(input logic [31:0] c);
        while (cyc < c) @(negedge clk);
    endtask

    // Drives now; the write is taken at the next rising edge, whose cycle number is returned
    task automatic wr(input logic [11:0] a, input logic [31:0] d, output logic [31:0] w);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
        w = cyc;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] w, w2, d, c0;
        int u0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_CTRL, d);  chk("R1 ctrl reset", d, 32'h0001_0000);
        rd(A_START, d); chk("R1 start reset", d, 0);
        rd(A_LIVE, d);  chk("R1 live reset", d, 0);
        rd(A_PSC, d);   chk("R1 psc reset", d, 0);
        wr(A_CTRL, 32'h0001_2345, w);
        rd(A_CTRL, d);  chk("R1 ctrl readback", d, 32'h0001_0045);
        wr(A_PSC, 32'hF, w);
        rd(A_PSC, d);   chk("R1 psc readback", d, 32'hB);

        // R4 / R2: one-shot, divide by 16, count 3
        wr(A_PSC, 32'h3, w);
        wr(A_CTRL, 32'h0000_0040, w);
        wr(A_START, 3, w);
        expect_irq(w + 48, 8'h40, "R4");
        rd(A_LIVE, d);  chk("R3 live loaded", d, 3);
        wait_cyc(w + 60);
        rd(A_LIVE, d);  chk("R4 live stays zero", d, 0);
        chk("R4 single irq", 64'(exp_q.size()), 0);

        // R5 / R12: periodic, divide by 1, count 5
        wr(A_PSC, 32'hB, w);
        wr(A_CTRL, 32'h0002_0041, w);
        wr(A_START, 5, w);
        expect_irq(w + 5, 8'h41, "R5");
        expect_irq(w + 10, 8'h41, "R5");
        expect_irq(w + 15, 8'h41, "R5");
        wait_cyc(w + 2);
        rd(A_LIVE, d);  chk("R3 live decrement", d, 3);
        wait_cyc(w + 16);
        u0 = n_unexp;
        wr(A_START, 0, w2);
        wait_cyc(w2 + 12);
        rd(A_LIVE, d);  chk("R7 live zero after stop", d, 0);
        chk("R7 no irq after stop", 64'(n_unexp - u0), 0);
        chk("R5 all periodic irqs", 64'(exp_q.size()), 0);

        // R6: masked expiries dropped, not held
        wr(A_CTRL, 32'h0003_0042, w);
        u0 = n_unexp;
        wr(A_START, 4, w);
        wait_cyc(w + 9);
        wr(A_CTRL, 32'h0002_0042, w2);
        expect_irq(w + 12, 8'h42, "R6");
        wait_cyc(w + 13);
        wr(A_START, 0, w2);
        wait_cyc(w2 + 8);
        chk("R6 masked irqs dropped", 64'(n_unexp - u0), 0);
        chk("R6 irq after unmask", 64'(exp_q.size()), 0);

        // R9: start write on the expiry edge
        wr(A_CTRL, 32'h0002_0043, w);
        wr(A_START, 4, w);
        expect_irq(w + 4, 8'h43, "R9");
        wait_cyc(w + 3);
        wr(A_START, 7, w2);
        rd(A_LIVE, d);  chk("R9 written value wins", d, 7);
        expect_irq(w2 + 7, 8'h43, "R9");
        wait_cyc(w2 + 8);
        wr(A_START, 0, w2);
        wait_cyc(w2 + 10);
        chk("R9 irqs", 64'(exp_q.size()), 0);

        // R8 / R2: divide by 4, prescaler restart on rewrite
        wr(A_PSC, 32'h1, w);
        wr(A_CTRL, 32'h0000_0044, w);
        wr(A_START, 2, w);
        wait_cyc(w + 2);
        wr(A_START, 2, w2);
        expect_irq(w2 + 8, 8'h44, "R8");
        wait_cyc(w2 + 14);
        chk("R8 restart timing", 64'(exp_q.size()), 0);

        // R3: longest interval
        wr(A_PSC, 32'hB, w);
        wr(A_CTRL, 32'h0001_0045, w);
        wr(A_START, 32'hFFFF_FFFF, w);
        wait_cyc(w + 10);
        rd(A_LIVE, d);  chk("R3 max count runs", d, 32'hFFFF_FFF5);
        rd(A_START, d); chk("R3 max count stored", d, 32'hFFFF_FFFF);
        wr(A_START, 0, w);

        // R10: future deadline, single fire
        wr(A_CTRL, 32'h0004_0050, w);
        c0 = cyc + 25;
        wr(A_DL_LO, c0, w);
        wr(A_DL_HI, 32'h1, w);
        expect_irq(c0 + 1, 8'h50, "R10");
        wait_cyc(c0 + 15);
        chk("R10 future deadline", 64'(exp_q.size()), 0);

        // R10: low half alone does not arm; high half arms a past deadline
        u0 = n_unexp;
        wr(A_DL_LO, 32'h5, w);
        wait_cyc(w + 10);
        chk("R10 low half only", 64'(n_unexp - u0), 0);
        wr(A_DL_HI, 32'h1, w);
        expect_irq(w + 1, 8'h50, "R10");
        wait_cyc(w + 10);
        chk("R10 past deadline", 64'(exp_q.size()), 0);

        // R11: zero deadline stays disarmed
        u0 = n_unexp;
        wr(A_DL_LO, 0, w);
        wr(A_DL_HI, 0, w);
        wait_cyc(w + 10);
        chk("R11 zero deadline silent", 64'(n_unexp - u0), 0);

        summary();
        $finish;
    end
endmodule